// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block keeps the protection state of a serial nonvolatile memory and decides, cycle by cycle, whether a write request may proceed. It holds the write enable latch, a two-bit block-protect level, a protect-enable bit that arms the external write-protect pin, and it mirrors the write engine's busy flag into the status byte. The command decoder feeds it strobes for the enable and disable opcodes and for a received status data byte. It also sees the chip-select level, so it can act on the rising edge of chip select that closes a command.

The array write grant is combinational on a supplied address. A status write is held pending while chip select stays low. It is committed on the rising edge of chip select, and a single-cycle grant pulse is raised alongside the update. A controller FSM with three states sequences this: `ST_IDLE` (nothing pending), `ST_ARM` (enable opcode seen, waiting for chip select to rise) and `ST_PEND` (status data held, waiting for chip select to rise). Its transitions are:

- ARM_REQ: `ST_IDLE`→`ST_ARM`, taken on the enable strobe when not busy.
- STS_TAKE: `ST_IDLE`→`ST_PEND`, taken on a status byte when the latch is set, the unit is not busy and hardware protection is off.
- ARM_DONE: `ST_ARM`→`ST_IDLE`, taken on the chip-select rise; it sets the latch.
- STS_ABORT: `ST_PEND`→`ST_IDLE`, taken when hardware protection becomes active.
- STS_COMMIT: `ST_PEND`→`ST_IDLE`, taken on the chip-select rise; it commits the pending byte.

Nonvolatile retention of the status bits is modelled as their reset value.

Top module: `stsreg_guard`

## Requirements
- R1: After reset the status byte reads 0x00 apart from bit 0, which follows `eng_busy`. `sts_commit` is 0.
- R2: The write enable latch (status bit 1) is set only in the clock edge that samples `cs_n` high for the first time after an accepted `op_wren` strobe. It is never set while chip select is still low.
- R3: The latch is cleared by an `op_wrdi` strobe and by an `eng_done` pulse.
- R4: A committed status write changes only bit 7 (protect-enable) and bits 3:2 (block-protect level). Bits 6:4 always read 0, and bits 1:0 are unaffected by the data byte.
- R5: While the latch is clear, no status write is committed and `arr_grant` is 0 for every address.
- R6: Hardware protection is active exactly when `wp_n` is 0 and status bit 7 is 1. While it is active a status write is refused. With `wp_n` high or bit 7 clear, the write is granted.
- R7: If hardware protection becomes active while a status write is pending (chip select still low), the write is dropped. A pin change after the commit has no effect on the committed bits.
- R8: `arr_grant` is 1 only when the latch is set, the unit is not busy, and `chk_addr` lies outside the protected range. With the address 13 bits wide, the ranges are: level 00 none, level 01 0x1800–0x1FFF, level 10 0x1000–0x1FFF, level 11 the whole array. Hardware protection does not change array grants.
- R9: Status bit 0 mirrors `eng_busy`. While busy, the `op_wren`, `op_wrdi` and `sts_wr_valid` strobes are ignored.
- R10: A commit raises `sts_commit` for exactly one cycle, in the same cycle in which the new bits first appear on `status_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip-select level, low while a command is active |
| op_wren | input | 1 | Enable-opcode strobe, one cycle |
| op_wrdi | input | 1 | Disable-opcode strobe, one cycle |
| sts_wr_valid | input | 1 | Status data byte received, one cycle |
| sts_wr_data | input | 8 | Status data byte |
| wp_n | input | 1 | Write-protect pin level, active low |
| eng_busy | input | 1 | Write engine cycle in progress |
| eng_done | input | 1 | Write engine cycle completed, one cycle |
| chk_addr | input | ADDR_W | Array address to check |
| status_byte | output | 8 | {protect-enable, 000, block-protect[1:0], latch, busy} |
| sts_commit | output | 1 | Status write granted and committed, one cycle |
| arr_grant | output | 1 | Array write at `chk_addr` allowed |

## Verification
The write-protect pin can fall in the same window as a pending status write closes. The bench provokes this by lowering `wp_n` one cycle after the data byte, while chip select is still low. It then expects the status byte unchanged and no commit pulse, whereas lowering the pin one cycle after the commit must leave the new bits in place. A second overlap tests the enable and disable strobes against an engine cycle that is running: strobes issued under `eng_busy` must leave the latch as it was, and the following `eng_done` pulse must clear it.

// File: rtl/stsreg_guard_pkg.sv
package stsreg_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_PEND = 2'd2
    } guard_state_e;

    typedef enum logic [1:0] {
        LVL_NONE    = 2'b00,
        LVL_QUARTER = 2'b01,
        LVL_HALF    = 2'b10,
        LVL_ALL     = 2'b11
    } prot_level_e;

    localparam int unsigned STS_W      = 8;
    localparam int unsigned BIT_BUSY   = 0;
    localparam int unsigned BIT_LATCH  = 1;
    localparam int unsigned BIT_LVL_LO = 2;
    localparam int unsigned BIT_LVL_HI = 3;
    localparam int unsigned BIT_ARMPIN = 7;

endpackage

// File: rtl/stsreg_guard_range.sv
module stsreg_guard_range
    import stsreg_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        level,
    output logic              in_range
);
    localparam int unsigned TOP = ADDR_W - 1;

    logic upper_half;
    logic upper_quarter;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign upper_half    = addr[TOP];
            assign upper_quarter = addr[TOP] & addr[TOP-1];
        end else begin : g_narrow
            assign upper_half    = addr[0];
            assign upper_quarter = addr[0];
        end
    endgenerate

    always_comb begin
        unique case (prot_level_e'(level))
            LVL_NONE:    in_range = 1'b0;
            LVL_QUARTER: in_range = upper_quarter;
            LVL_HALF:    in_range = upper_half;
            LVL_ALL:     in_range = 1'b1;
            default:     in_range = 1'b1;
        endcase
    end

endmodule

// File: rtl/stsreg_guard_fsm.sv
module stsreg_guard_fsm
    import stsreg_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_rise,
    input  logic op_wren,
    input  logic sts_valid,
    input  logic busy,
    input  logic latch,
    input  logic hw_prot,
    output logic set_latch,
    output logic take_data,
    output logic commit
);
    guard_state_e state_q;
    guard_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!busy && op_wren)
                    state_d = ST_ARM;
                else if (!busy && sts_valid && latch && !hw_prot)
                    state_d = ST_PEND;
            end
            ST_ARM: begin
                if (cs_rise) state_d = ST_IDLE;
            end
            ST_PEND: begin
                if (hw_prot)      state_d = ST_IDLE;
                else if (cs_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        set_latch = 1'b0;
        take_data = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE: take_data = !busy && !op_wren && sts_valid && latch && !hw_prot;
            ST_ARM:  set_latch = cs_rise;
            ST_PEND: commit    = cs_rise && !hw_prot && latch;
            default: ;
        endcase
    end

    // R7
    pend_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && hw_prot) |=> (state_q == ST_IDLE));

    // R6
    commit_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !hw_prot);

endmodule

// File: rtl/stsreg_guard_bits.sv
module stsreg_guard_bits
    import stsreg_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_latch,
    input  logic       clr_latch,
    input  logic       done,
    input  logic       take_data,
    input  logic [7:0] data,
    input  logic       commit,
    output logic       latch,
    output logic       arm_pin,
    output logic [1:0] level
);
    logic       latch_q;
    logic       arm_q;
    logic [1:0] lvl_q;
    logic       held_arm_q;
    logic [1:0] held_lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else if (set_latch) begin
            latch_q <= 1'b1;
        end else if (clr_latch || done) begin
            latch_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_arm_q <= 1'b0;
            held_lvl_q <= 2'b00;
        end else if (take_data) begin
            held_arm_q <= data[BIT_ARMPIN];
            held_lvl_q <= data[BIT_LVL_HI:BIT_LVL_LO];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            lvl_q <= 2'b00;
        end else if (commit) begin
            arm_q <= held_arm_q;
            lvl_q <= held_lvl_q;
        end
    end

    assign latch   = latch_q;
    assign arm_pin = arm_q;
    assign level   = lvl_q;

    // R3
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || clr_latch) && !set_latch) |=> !latch_q);

    // R4
    bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({arm_q, lvl_q}));

endmodule

// File: rtl/stsreg_guard.sv
module stsreg_guard
    import stsreg_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              op_wren,
    input  logic              op_wrdi,
    input  logic              sts_wr_valid,
    input  logic [7:0]        sts_wr_data,
    input  logic              wp_n,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        status_byte,
    output logic              sts_commit,
    output logic              arr_grant
);
    logic       cs_q;
    logic       cs_rise;
    logic       latch;
    logic       arm_pin;
    logic [1:0] level;
    logic       hw_prot;
    logic       set_latch;
    logic       take_data;
    logic       commit;
    logic       commit_q;
    logic       addr_prot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q     <= 1'b1;
            commit_q <= 1'b0;
        end else begin
            cs_q     <= cs_n;
            commit_q <= commit;
        end
    end

    assign cs_rise = cs_n & ~cs_q;
    assign hw_prot = ~wp_n & arm_pin;

    stsreg_guard_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_rise   (cs_rise),
        .op_wren   (op_wren),
        .sts_valid (sts_wr_valid),
        .busy      (eng_busy),
        .latch     (latch),
        .hw_prot   (hw_prot),
        .set_latch (set_latch),
        .take_data (take_data),
        .commit    (commit)
    );

    stsreg_guard_bits u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_latch (set_latch),
        .clr_latch (op_wrdi & ~eng_busy),
        .done      (eng_done),
        .take_data (take_data),
        .data      (sts_wr_data),
        .commit    (commit),
        .latch     (latch),
        .arm_pin   (arm_pin),
        .level     (level)
    );

    stsreg_guard_range #(.ADDR_W(ADDR_W)) u_range (
        .addr     (chk_addr),
        .level    (level),
        .in_range (addr_prot)
    );

    assign arr_grant   = latch & ~eng_busy & ~addr_prot;
    assign sts_commit  = commit_q;
    assign status_byte = {arm_pin, 3'b000, level, latch, eng_busy};

    // R8
    arr_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant |-> (status_byte[BIT_LATCH] && !eng_busy));

    // R2
    latch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[BIT_LATCH]) |-> $past(cs_n));

    // R10
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_commit |=> !sts_commit);

endmodule

// File: tb/test_stsreg_guard.sv
`timescale 1ns/1ps
module test_stsreg_guard;
    localparam int ADDR_W = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              op_wren = 1'b0;
    logic              op_wrdi = 1'b0;
    logic              sts_wr_valid = 1'b0;
    logic [7:0]        sts_wr_data = 8'h00;
    logic              wp_n = 1'b1;
    logic              eng_busy = 1'b0;
    logic              eng_done = 1'b0;
    logic [ADDR_W-1:0] chk_addr = '0;
    logic [7:0]        status_byte;
    logic              sts_commit;
    logic              arr_grant;

    int n_run = 0;
    int n_fail = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    stsreg_guard #(.ADDR_W(ADDR_W)) i_stsreg_guard (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .op_wren(op_wren),
        .op_wrdi(op_wrdi), .sts_wr_valid(sts_wr_valid),
        .sts_wr_data(sts_wr_data), .wp_n(wp_n), .eng_busy(eng_busy),
        .eng_done(eng_done), .chk_addr(chk_addr),
        .status_byte(status_byte), .sts_commit(sts_commit),
        .arr_grant(arr_grant)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_wren();
        cs_n = 1'b0; tick();
        op_wren = 1'b1; tick();
        op_wren = 1'b0; tick();
        cs_n = 1'b1; tick();
    endtask

    task automatic do_wrdi();
        cs_n = 1'b0; tick();
        op_wrdi = 1'b1; tick();
        op_wrdi = 1'b0; cs_n = 1'b1; tick();
    endtask

    task automatic do_sts(input logic [7:0] d);
        cs_n = 1'b0; tick();
        sts_wr_valid = 1'b1; sts_wr_data = d; tick();
        sts_wr_valid = 1'b0; tick();
        cs_n = 1'b1; tick();
    endtask

    task automatic do_cycle();
        eng_busy = 1'b1; tick(); tick();
        eng_done = 1'b1; tick();
        eng_done = 1'b0; eng_busy = 1'b0; tick();
    endtask

    function automatic logic exp_prot(input int lvl, input int a);
        case (lvl)
            0: return 1'b0;
            1: return a >= 32'h1800;
            2: return a >= 32'h1000;
            default: return 1'b1;
        endcase
    endfunction

    // safe setting of protect-enable and level with the pin high
    task automatic set_sts(input logic [7:0] d);
        logic wp_save;
        wp_save = wp_n;
        wp_n = 1'b1;
        do_wren();
        do_sts(d);
        do_cycle();
        wp_n = wp_save;
        tick();
    endtask

    initial begin
        #1_500_000;
        if (!ended) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R1 reset state
        chk(status_byte, 8'h00, "R1 status in reset");
        rst_n = 1'b1; tick();
        chk(status_byte, 8'h00, "R1 status after reset");
        chk(sts_commit, 1'b0, "R1 commit idle");
        eng_busy = 1'b1; tick();
        chk(status_byte, 8'h01, "R1 busy bit follows engine");
        eng_busy = 1'b0; tick();

        // R2 latch set only after chip select rises
        cs_n = 1'b0; tick();
        op_wren = 1'b1; tick();
        op_wren = 1'b0; tick(); tick();
        chk(status_byte[1], 1'b0, "R2 latch still clear with cs low");
        cs_n = 1'b1; tick();
        chk(status_byte[1], 1'b1, "R2 latch set after cs rise");

        // R3 disable opcode clears
        do_wrdi();
        chk(status_byte[1], 1'b0, "R3 latch cleared by disable");
        do_wren();
        chk(status_byte[1], 1'b1, "R3 latch set again");
        eng_done = 1'b1; tick();
        eng_done = 1'b0;
        chk(status_byte[1], 1'b0, "R3 latch cleared by done");

        // R5 status write without latch is refused
        do_sts(8'h8C);
        chk(status_byte, 8'h00, "R5 status unchanged without latch");
        chk(sts_commit, 1'b0, "R5 no commit without latch");
        for (int a = 0; a < (1 << ADDR_W); a += 97) begin
            chk_addr = a[ADDR_W-1:0]; #2;
            chk(arr_grant, 1'b0, "R5 no array grant without latch");
        end

        // R4 / R10 sweep of every data byte
        for (int d = 0; d < 256; d++) begin
            logic [7:0] e;
            do_wren();
            do_sts(d[7:0]);
            e = {d[7], 3'b000, d[3:2], 2'b10};
            chk(status_byte, {24'h0, e}, "R4 writable bits only");
            chk(sts_commit, 1'b1, "R10 commit pulse high");
            tick();
            chk(sts_commit, 1'b0, "R10 commit pulse one cycle");
            do_cycle();
            chk(status_byte[1], 1'b0, "R3 latch cleared after cycle");
        end

        // R6 hardware protection matrix
        for (int pe = 0; pe < 2; pe++) begin
            for (int pin = 0; pin < 2; pin++) begin
                logic allow;
                set_sts({pe[0], 7'h00});
                wp_n = pin[0];
                do_wren();
                do_sts({pe[0], 7'h08});
                allow = !(pe == 1 && pin == 0);
                chk(sts_commit, allow, "R6 commit under pin/enable");
                chk(status_byte[3:2], allow ? 2'b10 : 2'b00, "R6 level after attempt");
                do_cycle();
                wp_n = 1'b1; tick();
            end
        end

        // R7 pin drop while pending aborts
        set_sts(8'h80);
        do_wren();
        cs_n = 1'b0; tick();
        sts_wr_valid = 1'b1; sts_wr_data = 8'h8C; tick();
        sts_wr_valid = 1'b0; wp_n = 1'b0; tick();
        cs_n = 1'b1; tick();
        chk(sts_commit, 1'b0, "R7 pending write dropped");
        chk(status_byte, 8'h82, "R7 status unchanged after abort");
        wp_n = 1'b1; tick();
        do_sts(8'h84);
        wp_n = 1'b0; tick(); tick();
        chk(status_byte[7:2], 6'b100001, "R7 pin after commit has no effect");
        wp_n = 1'b1;
        do_cycle();
        set_sts(8'h00);

        // R8 full address sweep for every level
        for (int lvl = 0; lvl < 4; lvl++) begin
            set_sts({4'h0, lvl[1:0], 2'b00});
            do_wren();
            for (int a = 0; a < (1 << ADDR_W); a++) begin
                chk_addr = a[ADDR_W-1:0]; #2;
                chk(arr_grant, !exp_prot(lvl, a), "R8 array grant by level");
            end
            // hardware protection leaves array grants alone
            set_sts(8'h00);
        end
        set_sts(8'h84);
        do_wren();
        wp_n = 1'b0; tick();
        chk_addr = 13'h0100; #2;
        chk(arr_grant, 1'b1, "R8 unprotected block writable under pin");
        chk_addr = 13'h1900; #2;
        chk(arr_grant, 1'b0, "R8 protected block refused under pin");
        wp_n = 1'b1; tick();

        // R9 busy mirrors and strobes ignored
        chk_addr = 13'h0100;
        eng_busy = 1'b1; tick();
        chk(status_byte[0], 1'b1, "R9 busy bit set");
        chk(arr_grant, 1'b0, "R9 no array grant while busy");
        do_wrdi();
        chk(status_byte[1], 1'b1, "R9 disable ignored while busy");
        do_sts(8'h00);
        chk(status_byte[3:2], 2'b01, "R9 status write ignored while busy");
        eng_busy = 1'b0; tick();
        do_wrdi();
        chk(status_byte[1], 1'b0, "R9 disable works when idle");
        eng_busy = 1'b1; tick();
        do_wren();
        chk(status_byte[1], 1'b0, "R9 enable ignored while busy");
        eng_busy = 1'b0; tick();
        chk(status_byte[0], 1'b0, "R9 busy bit clear");

        ended = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule